// File: doc/BRIEF.md
# Subranging converter error-correction merge

This block sits behind the four flash stages of a subranging analog-to-digital converter. It builds the final 12-bit sample from the stages' raw decision codes. The first stage gives a 3-bit code and the second stage a 3-bit code. The back end gives a 4-bit coarse code and a 4-bit fine code. Each redundant stage overlaps the stage before it by one bit. The stage codes are therefore weighted, added with shifts, and a fixed mid-scale offset is removed. This lets a wrong early decision be repaired by the later stages instead of reaching the output.

Each stage code has its own capture strobe. The fine code is not stored: it is taken straight from its input when its strobe arrives. That strobe also commits the conversion. The outputs are the data word, a complemented MSB and an out-of-range flag, and all three are registered. An analog range status can force the data to either rail. Arithmetic overflow and underflow of the merged sum are also clamped to the rails. A format select gives either straight/offset binary or two's complement data.

Top module: `subrange_corrector`

## Requirements
- R1: Each of the first three stage codes is stored when its own strobe is high at a clock edge. It keeps that value until that stage's next strobe, so later commits reuse it. After reset all three stored codes are zero.
- R2: `dataOut`, `msbNOut` and `otrOut` change only at a clock edge where `st4Stb` is high. Strobes of other stages, and changes of `rangeFlag` or `fmtTwos`, leave them unchanged.
- R3: On a commit, the merged value is V = st1·512 + st2·128 + st3·16 + st4 − 320. Here st1 to st3 are the stored codes and st4 is `st4Code` at that edge. If 0 ≤ V ≤ 4095, the straight word is V and `otrOut` is 0.
- R4: If V > 4095, the straight word is 0xFFF and `otrOut` is 1.
- R5: If V < 0, the straight word is 0x000 and `otrOut` is 1.
- R6: `rangeFlag[1]` (above range) at the commit forces the straight word to 0xFFF with `otrOut` 1. Otherwise `rangeFlag[0]` (below range) forces 0x000 with `otrOut` 1. Both take precedence over the arithmetic result. `rangeFlag` is sampled only at the commit edge.
- R7: `msbNOut` is the complement of bit 11 of the straight word, in both formats. With `otrOut` 1, `msbNOut` 0 therefore means overrange and `msbNOut` 1 means underrange.
- R8: With `fmtTwos` 0 at the commit, `dataOut` equals the straight word. With `fmtTwos` 1, `dataOut` is the straight word with bit 11 inverted. `fmtTwos` is sampled only at the commit edge.
- R9: After reset, `dataOut` is 0x000, `otrOut` is 0 and `msbNOut` is 1.
- R10: A stage strobe at the same edge as a commit does not affect that commit. The value it captures is used from the next commit on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| st1Code | input | 3 | First-stage flash code |
| st1Stb | input | 1 | Capture strobe for st1Code |
| st2Code | input | 3 | Second-stage flash code |
| st2Stb | input | 1 | Capture strobe for st2Code |
| st3Code | input | 4 | Back-end coarse code |
| st3Stb | input | 1 | Capture strobe for st3Code |
| st4Code | input | 4 | Back-end fine code, used directly |
| st4Stb | input | 1 | Fine strobe; commits the conversion |
| rangeFlag | input | 2 | Bit 1 above range, bit 0 below range |
| fmtTwos | input | 1 | 1 selects two's complement output |
| dataOut | output | 12 | Corrected data word |
| msbNOut | output | 1 | Complement of straight MSB |
| otrOut | output | 1 | Out-of-range flag |

## Verification
A stored stage code that is stale or mis-captured shows up only at the next commit, one cycle after the fine strobe. It appears as a data word off by a multiple of that stage's weight, so each vector changes one stage against a known neighbour. A wrong offset or shift shifts every in-range code by a constant, and the exact-rail vectors (0x000 and 0xFFF with the flag clear) expose it at once. A wrong clamp selection or precedence appears as `otrOut` set with data off the rails, or with the wrong `msbNOut`, on the cycle after the commit.

// File: rtl/subrange_pkg.sv
package subrange_pkg;

  typedef enum logic [1:0] {
    SEL_PASS = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_LOW  = 2'd2
  } clampSel_e;

  typedef struct packed {
    logic      cap1;
    logic      cap2;
    logic      cap3;
    logic      commit;
    clampSel_e sel;
  } ctrlStrobes_t;

endpackage

// File: rtl/subrange_ctrl.sv
module subrange_ctrl
  import subrange_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         st1Stb,
  input  logic         st2Stb,
  input  logic         st3Stb,
  input  logic         st4Stb,
  input  logic [1:0]   rangeFlag,
  input  logic         sumOver,
  input  logic         sumUnder,
  output ctrlStrobes_t ctrl
);

  clampSel_e selNext;

  // Precedence: analog above-range, analog below-range, then arithmetic rails.
  always_comb begin
    if (rangeFlag[1])      selNext = SEL_HIGH;
    else if (rangeFlag[0]) selNext = SEL_LOW;
    else if (sumOver)      selNext = SEL_HIGH;
    else if (sumUnder)     selNext = SEL_LOW;
    else                   selNext = SEL_PASS;
  end

  always_comb begin
    ctrl.cap1   = st1Stb;
    ctrl.cap2   = st2Stb;
    ctrl.cap3   = st3Stb;
    ctrl.commit = st4Stb;
    ctrl.sel    = selNext;
  end

  // R3: the merged sum can never be above and below range together
  p_sum_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(sumOver && sumUnder));

endmodule

// File: rtl/subrange_datapath.sv
module subrange_datapath
  import subrange_pkg::*;
#(
  parameter int S1W = 3,
  parameter int S2W = 3,
  parameter int S3W = 4,
  parameter int S4W = 4,
  localparam int SH3  = S4W,
  localparam int SH2  = SH3 + S3W - 1,
  localparam int SH1  = SH2 + S2W - 1,
  localparam int OUTW = SH1 + S1W
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic [S1W-1:0]  st1Code,
  input  logic [S2W-1:0]  st2Code,
  input  logic [S3W-1:0]  st3Code,
  input  logic [S4W-1:0]  st4Code,
  input  logic            fmtTwos,
  input  ctrlStrobes_t    ctrl,
  output logic            sumOver,
  output logic            sumUnder,
  output logic [OUTW-1:0] dataOut,
  output logic            msbNOut,
  output logic            otrOut
);

  localparam int SUMW   = OUTW + 2;
  localparam int OFF2   = 1 << (S2W - 2);
  localparam int OFF3   = 1 << (S3W - 2);
  localparam int OFFSET = (OFF2 << SH2) + (OFF3 << SH3);

  logic [S1W-1:0]  st1Q;
  logic [S2W-1:0]  st2Q;
  logic [S3W-1:0]  st3Q;
  logic [SUMW-1:0] rawSum;
  logic [SUMW-1:0] corrSum;
  logic [OUTW-1:0] nextWord;
  logic [OUTW-1:0] wordQ;
  logic            nextOtr;

  // Stage capture registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st1Q <= '0;
      st2Q <= '0;
      st3Q <= '0;
    end else begin
      if (ctrl.cap1) st1Q <= st1Code;
      if (ctrl.cap2) st2Q <= st2Code;
      if (ctrl.cap3) st3Q <= st3Code;
    end
  end

  // Shifted add of overlapping stages, then mid-scale offset removal
  always_comb begin
    rawSum = (SUMW'(st1Q) << SH1) + (SUMW'(st2Q) << SH2)
           + (SUMW'(st3Q) << SH3) + SUMW'(st4Code);
    corrSum  = rawSum - SUMW'(OFFSET);
    sumUnder = corrSum[SUMW-1];
    sumOver  = !corrSum[SUMW-1] && (|corrSum[SUMW-2:OUTW]);
  end

  always_comb begin
    case (ctrl.sel)
      SEL_HIGH: nextWord = '1;
      SEL_LOW:  nextWord = '0;
      default:  nextWord = corrSum[OUTW-1:0];
    endcase
    nextOtr = (ctrl.sel != SEL_PASS);
  end

  // Output registers, loaded only on commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ   <= '0;
      dataOut <= '0;
      msbNOut <= 1'b1;
      otrOut  <= 1'b0;
    end else if (ctrl.commit) begin
      wordQ   <= nextWord;
      dataOut <= {nextWord[OUTW-1] ^ fmtTwos, nextWord[OUTW-2:0]};
      msbNOut <= ~nextWord[OUTW-1];
      otrOut  <= nextOtr;
    end
  end

  p_cap1_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.cap1 |=> st1Q == $past(st1Code));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.commit |=> $stable(dataOut) && $stable(otrOut) && $stable(msbNOut));

  // R4 / R5: a raised flag always comes with a rail word
  p_otr_rail_r5: assert property (@(posedge clk) disable iff (!rstN)
    otrOut |-> (wordQ == '1 || wordQ == '0));

  p_msbn_r7: assert property (@(posedge clk) disable iff (!rstN)
    msbNOut == !wordQ[OUTW-1]);

  p_fmt_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.commit |=> dataOut[OUTW-1] == ($past(fmtTwos) ^ wordQ[OUTW-1]));

endmodule

// File: rtl/subrange_corrector.sv
module subrange_corrector
  import subrange_pkg::*;
#(
  parameter int S1W = 3,
  parameter int S2W = 3,
  parameter int S3W = 4,
  parameter int S4W = 4,
  localparam int OUTW = S4W + (S3W - 1) + (S2W - 1) + S1W
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic [S1W-1:0]  st1Code,
  input  logic            st1Stb,
  input  logic [S2W-1:0]  st2Code,
  input  logic            st2Stb,
  input  logic [S3W-1:0]  st3Code,
  input  logic            st3Stb,
  input  logic [S4W-1:0]  st4Code,
  input  logic            st4Stb,
  input  logic [1:0]      rangeFlag,
  input  logic            fmtTwos,
  output logic [OUTW-1:0] dataOut,
  output logic            msbNOut,
  output logic            otrOut
);

  ctrlStrobes_t ctrl;
  logic         sumOver;
  logic         sumUnder;

  subrange_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .st1Stb    (st1Stb),
    .st2Stb    (st2Stb),
    .st3Stb    (st3Stb),
    .st4Stb    (st4Stb),
    .rangeFlag (rangeFlag),
    .sumOver   (sumOver),
    .sumUnder  (sumUnder),
    .ctrl      (ctrl)
  );

  subrange_datapath #(
    .S1W (S1W),
    .S2W (S2W),
    .S3W (S3W),
    .S4W (S4W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .st1Code  (st1Code),
    .st2Code  (st2Code),
    .st3Code  (st3Code),
    .st4Code  (st4Code),
    .fmtTwos  (fmtTwos),
    .ctrl     (ctrl),
    .sumOver  (sumOver),
    .sumUnder (sumUnder),
    .dataOut  (dataOut),
    .msbNOut  (msbNOut),
    .otrOut   (otrOut)
  );

  p_range_hi_r6: assert property (@(posedge clk) disable iff (!rstN)
    st4Stb && rangeFlag[1] |=> otrOut && !msbNOut && (dataOut[OUTW-2:0] == '1));

endmodule

// File: tb/subrange_corrector_test.sv
`timescale 1ns/1ps
module subrange_corrector_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  st1Code = '0;
  logic        st1Stb = 1'b0;
  logic [2:0]  st2Code = '0;
  logic        st2Stb = 1'b0;
  logic [3:0]  st3Code = '0;
  logic        st3Stb = 1'b0;
  logic [3:0]  st4Code = '0;
  logic        st4Stb = 1'b0;
  logic [1:0]  rangeFlag = '0;
  logic        fmtTwos = 1'b0;
  logic [11:0] dataOut;
  logic        msbNOut;
  logic        otrOut;

  int checkCount = 0;
  int failCount = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  subrange_corrector uut (
    .clk(clk), .rstN(rstN),
    .st1Code(st1Code), .st1Stb(st1Stb),
    .st2Code(st2Code), .st2Stb(st2Stb),
    .st3Code(st3Code), .st3Stb(st3Stb),
    .st4Code(st4Code), .st4Stb(st4Stb),
    .rangeFlag(rangeFlag), .fmtTwos(fmtTwos),
    .dataOut(dataOut), .msbNOut(msbNOut), .otrOut(otrOut)
  );

  typedef struct packed {
    logic [2:0]  s1;
    logic [2:0]  s2;
    logic [3:0]  s3;
    logic [3:0]  s4;
    logic [1:0]  rng;
    logic        fmt;
    logic [11:0] expData;
    logic        expOtr;
    logic        expMsbN;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 3'd2, 4'd4,  4'd0,  2'b00, 1'b0, 12'h000, 1'b0, 1'b1, 4'd3}, // R3 lowest
    '{3'd7, 3'd5, 4'd11, 4'd15, 2'b00, 1'b0, 12'hFFF, 1'b0, 1'b0, 4'd3}, // R3 highest
    '{3'd4, 3'd2, 4'd4,  4'd0,  2'b00, 1'b0, 12'h800, 1'b0, 1'b0, 4'd3},
    '{3'd3, 3'd6, 4'd4,  4'd0,  2'b00, 1'b0, 12'h800, 1'b0, 1'b0, 4'd3}, // R3 correction
    '{3'd2, 3'd1, 4'd9,  4'd7,  2'b00, 1'b0, 12'h3D7, 1'b0, 1'b1, 4'd3},
    '{3'd2, 3'd1, 4'd9,  4'd7,  2'b00, 1'b1, 12'hBD7, 1'b0, 1'b1, 4'd8}, // R8
    '{3'd5, 3'd3, 4'd7,  4'd10, 2'b00, 1'b1, 12'h2BA, 1'b0, 1'b0, 4'd8},
    '{3'd4, 3'd2, 4'd4,  4'd1,  2'b00, 1'b1, 12'h001, 1'b0, 1'b0, 4'd7}, // R7
    '{3'd7, 3'd7, 4'd15, 4'd15, 2'b00, 1'b0, 12'hFFF, 1'b1, 1'b0, 4'd4}, // R4
    '{3'd7, 3'd7, 4'd15, 4'd15, 2'b00, 1'b1, 12'h7FF, 1'b1, 1'b0, 4'd4},
    '{3'd0, 3'd2, 4'd3,  4'd15, 2'b00, 1'b0, 12'h000, 1'b1, 1'b1, 4'd5}, // R5 just below
    '{3'd0, 3'd0, 4'd0,  4'd5,  2'b00, 1'b1, 12'h800, 1'b1, 1'b1, 4'd5},
    '{3'd4, 3'd2, 4'd4,  4'd0,  2'b10, 1'b0, 12'hFFF, 1'b1, 1'b0, 4'd6}, // R6
    '{3'd4, 3'd2, 4'd4,  4'd0,  2'b01, 1'b0, 12'h000, 1'b1, 1'b1, 4'd6},
    '{3'd4, 3'd2, 4'd4,  4'd0,  2'b11, 1'b1, 12'h7FF, 1'b1, 1'b0, 4'd6},
    '{3'd7, 3'd5, 4'd11, 4'd15, 2'b01, 1'b1, 12'h800, 1'b1, 1'b1, 4'd6}
  };

  task automatic checkOut(string req, logic [11:0] eData, logic eOtr, logic eMsbN);
    checkCount++;
    if (dataOut !== eData || otrOut !== eOtr || msbNOut !== eMsbN) begin
      failCount++;
      $display("FAIL %s: data=%h otr=%b msbN=%b expected data=%h otr=%b msbN=%b",
               req, dataOut, otrOut, msbNOut, eData, eOtr, eMsbN);
    end
  endtask

  task automatic capStages(logic [2:0] a, logic [2:0] b, logic [3:0] c);
    @(negedge clk); st1Code = a; st1Stb = 1'b1;
    @(negedge clk); st1Stb = 1'b0; st2Code = b; st2Stb = 1'b1;
    @(negedge clk); st2Stb = 1'b0; st3Code = c; st3Stb = 1'b1;
    @(negedge clk); st3Stb = 1'b0;
  endtask

  task automatic commit(logic [3:0] d, logic [1:0] rng, logic fmt);
    st4Code = d; rangeFlag = rng; fmtTwos = fmt; st4Stb = 1'b1;
    @(negedge clk); st4Stb = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R9 reset", 12'h000, 1'b0, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R9 idle", 12'h000, 1'b0, 1'b1);

    // R1 / R9: stored codes reset to zero, so 3 - 320 is below range
    commit(4'd3, 2'b00, 1'b0);
    checkOut("R1 reset stage codes", 12'h000, 1'b1, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      capStages(VECS[i].s1, VECS[i].s2, VECS[i].s3);
      commit(VECS[i].s4, VECS[i].rng, VECS[i].fmt);
      checkOut($sformatf("R%0d vector %0d", VECS[i].req, i),
               VECS[i].expData, VECS[i].expOtr, VECS[i].expMsbN);
    end

    // R2: captures, range and format changes without commit leave outputs alone
    capStages(3'd4, 3'd2, 4'd4);
    commit(4'd0, 2'b00, 1'b0);
    checkOut("R2 setup", 12'h800, 1'b0, 1'b0);
    capStages(3'd0, 3'd0, 4'd0);
    rangeFlag = 2'b10; fmtTwos = 1'b1;
    repeat (2) @(negedge clk);
    checkOut("R2 hold", 12'h800, 1'b0, 1'b0);
    // R1: the silently captured codes take effect at the next commit
    commit(4'd5, 2'b00, 1'b0);
    checkOut("R1 captured", 12'h000, 1'b1, 1'b1);

    // R10: stage strobe at the commit edge applies to the next commit only
    capStages(3'd4, 3'd2, 4'd4);
    st1Code = 3'd0; st1Stb = 1'b1;
    commit(4'd0, 2'b00, 1'b0);
    st1Stb = 1'b0;
    checkOut("R10 same-edge", 12'h800, 1'b0, 1'b0);
    commit(4'd0, 2'b00, 1'b0);
    checkOut("R10 next commit", 12'h000, 1'b0, 1'b1);

    // R1: stored codes reused across commits
    commit(4'd7, 2'b00, 1'b0);
    checkOut("R1 reuse", 12'h007, 1'b0, 1'b1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule